// File: doc/BRIEF.md
# Nonvolatile Configuration PROM Image Writer

This block copies an image of 16-bit words from a source buffer into a slow nonvolatile configuration PROM. The PROM accepts words through a memory-mapped word port. Writes to the PROM are only allowed while a write-enable bit is set in a separate control register.

On a start request the sequencer runs a fixed program. It sets the enable bit with a read-modify-write of the control register and then waits an enable guard time. Next it fetches the words one by one and strobes each into the PROM, with a programming delay after every word. It then clears the enable bit with a second read-modify-write, waits a closing guard time, and pulses done. Three progress markers appear at the quarter, half and three-quarter points of the image.

All delays are given in milliseconds and converted to clock cycles from a clock-frequency parameter. A simulation can therefore run with a small tick. An error reported on any control-register access ends the job with an error pulse instead of done.

Top module: `prom_seq`

## Requirements
- R1: While reset is asserted, and after it is released, all of these outputs are 0 until a start is accepted: `busy_o`, `done_o`, `err_o`, `src_rd_o`, `ctl_req_o`, `prom_wr_o`, `mark_o`.
- R2: A start is accepted only when the block is idle, and `size_i` is captured at that moment. `busy_o` is 1 from the cycle after the accepting edge. It stays 1 until the cycle in which `done_o` or `err_o` shows, and in that cycle it is 0. A start pulse while busy has no effect.
- R3: Each control access holds `ctl_req_o`, `ctl_we_o` and `ctl_wdata_o` steady until the cycle with `ctl_ack_i`. The job first reads the control register. It then writes back the value read with bit `WE_BIT` set, and every other bit stays as read.
- R4: The first PROM strobe is seen EN_CYC+3 cycles after the cycle in which the enabling write is acknowledged. EN_CYC is CLK_HZ/1000 times ENABLE_MS.
- R5: Word i is requested with `src_rd_o` and `src_idx_o`=i. `src_data_i` is taken in the following cycle. Two cycles after the request, the word is strobed with `prom_addr_o` = PROM_BASE + 2*i. Words go out in ascending order, exactly `size` of them.
- R6: Consecutive PROM strobes are exactly WORD_CYC+2 cycles apart. WORD_CYC is CLK_HZ/1000 times WORD_MS.
- R7: The read that starts disabling is requested WORD_CYC cycles after the last strobe. The write that follows carries the value read with bit `WE_BIT` cleared and every other bit as read.
- R8: `done_o` pulses for one cycle, DONE_CYC+1 cycles after the cycle in which the disabling write is acknowledged. DONE_CYC is CLK_HZ/1000 times DONE_MS.
- R9: `mark_o` is nonzero only in a strobe cycle. It is 1 at index size/4, 2 at size/2 and 3 at 3*size/4, using integer division. When two of these indices are equal, the lower code wins.
- R10: With size 0 there are no source reads and no strobes. The enable and disable accesses still happen. The disable read is requested EN_CYC+1 cycles after the enabling write is acknowledged, and done follows as in R8.
- R11: An error on the enabling read gives `err_o` in the next cycle. No control write follows and no strobe occurs.
- R12: An error on the enabling write makes the block run the disable read-modify-write with no strobes. It then raises `err_o` in the cycle after that write is acknowledged, whatever its outcome, and never raises `done_o`.
- R13: An error on the disabling read or the disabling write gives `err_o` in the next cycle, with no closing wait. No further control access follows.
- R14: `done_o` and `err_o` are never 1 in the same cycle, and exactly one of them pulses per job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, honoured when idle |
| size_i | input | SIZE_W | Image length in words |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle pulse on normal completion |
| err_o | output | 1 | One-cycle pulse on abort after a control error |
| src_rd_o | output | 1 | Source word request |
| src_idx_o | output | SIZE_W | Index of the requested word |
| src_data_i | input | DATA_W | Source word, valid the cycle after the request |
| ctl_req_o | output | 1 | Control register access request |
| ctl_we_o | output | 1 | 1 for a write access, 0 for a read |
| ctl_wdata_o | output | CTL_W | Control write data |
| ctl_rdata_i | input | CTL_W | Control read data, valid with ack |
| ctl_ack_i | input | 1 | Access complete |
| ctl_err_i | input | 1 | Access failed, valid with ack |
| prom_wr_o | output | 1 | PROM word write strobe |
| prom_addr_o | output | ADDR_W | PROM byte address |
| prom_data_o | output | DATA_W | PROM word data |
| mark_o | output | 2 | Progress marker code, 0 when none |

## Verification
If the shared delay counter is loaded with a wrong value, the fault appears as a strobe spacing that is off by a cycle or more. It shows on the first word, the second word, or the done pulse, depending on which of the three guard times is wrong. If the word index goes wrong, the next strobe carries a wrong address, wrong data or a marker in the wrong place. If the saved control value goes wrong, the very next control write carries other bits that were not preserved, within a few cycles of the read. A wrong abort state shows as a missing or late error pulse, or as an extra control access after the failing acknowledge.

// File: rtl/prom_seq_pkg.sv
package prom_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_EN_RD, S_EN_WR, S_SETTLE, S_FETCH,
    S_CAPT, S_GAP, S_DIS_RD, S_DIS_WR, S_TAIL
  } seq_state_e;

  typedef enum logic [1:0] {
    MK_NONE = 2'd0, MK_Q1 = 2'd1, MK_HALF = 2'd2, MK_Q3 = 2'd3
  } mark_e;
endpackage

// File: rtl/prom_seq_timer.sv
module prom_seq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= load_val_i;
    else if (cnt_q != '0)        cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/prom_seq_marks.sv
module prom_seq_marks
  import prom_seq_pkg::*;
#(
  parameter int unsigned SIZE_W = 9
) (
  input  logic [SIZE_W-1:0] size_i,
  input  logic [SIZE_W-1:0] idx_i,
  output mark_e             mark_o
);
  localparam int unsigned EW = SIZE_W + 2;

  logic [EW-1:0] sz, ix, q1, half, q3;

  always_comb begin
    sz   = EW'(size_i);
    ix   = EW'(idx_i);
    q1   = sz >> 2;
    half = sz >> 1;
    q3   = ((sz << 1) + sz) >> 2;
    // lowest code wins when points coincide on short images
    if (ix == q1)        mark_o = MK_Q1;
    else if (ix == half) mark_o = MK_HALF;
    else if (ix == q3)   mark_o = MK_Q3;
    else                 mark_o = MK_NONE;
  end
endmodule

// File: rtl/prom_seq.sv
module prom_seq
  import prom_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned ENABLE_MS  = 500,
  parameter int unsigned WORD_MS    = 20,
  parameter int unsigned DONE_MS    = 500,
  parameter int unsigned SIZE_W     = 9,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned CTL_W      = 32,
  parameter int unsigned WE_BIT     = 4,
  parameter logic [ADDR_W-1:0] PROM_BASE = 'h1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              src_rd_o,
  output logic [SIZE_W-1:0] src_idx_o,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              ctl_req_o,
  output logic              ctl_we_o,
  output logic [CTL_W-1:0]  ctl_wdata_o,
  input  logic [CTL_W-1:0]  ctl_rdata_i,
  input  logic              ctl_ack_i,
  input  logic              ctl_err_i,
  output logic              prom_wr_o,
  output logic [ADDR_W-1:0] prom_addr_o,
  output logic [DATA_W-1:0] prom_data_o,
  output logic [1:0]        mark_o
);
  localparam int unsigned CYC_MS   = CLK_HZ / 1000;
  localparam int unsigned EN_CYC   = CYC_MS * ENABLE_MS;
  localparam int unsigned WORD_CYC = CYC_MS * WORD_MS;
  localparam int unsigned DONE_CYC = CYC_MS * DONE_MS;
  localparam int unsigned MAX_A    = (EN_CYC > DONE_CYC) ? EN_CYC : DONE_CYC;
  localparam int unsigned MAX_CYC  = (MAX_A > WORD_CYC) ? MAX_A : WORD_CYC;
  localparam int unsigned TMR_W    = $clog2(MAX_CYC + 1);
  localparam logic [CTL_W-1:0] WE_MASK = CTL_W'(1) << WE_BIT;

  seq_state_e        state_q;
  logic [SIZE_W-1:0] size_q, idx_q;
  logic [CTL_W-1:0]  shadow_q;
  logic              abort_q;
  logic              prom_wr_q, done_q, err_q;
  logic [ADDR_W-1:0] prom_addr_q;
  logic [DATA_W-1:0] prom_data_q;
  mark_e             mark_q, mark_n;
  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              ack_ok;

  assign ack_ok = ctl_ack_i && !ctl_err_i;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      S_EN_WR: if (ack_ok) begin
        tmr_load = 1'b1; tmr_val = TMR_W'(EN_CYC - 1);
      end
      S_CAPT: begin
        tmr_load = 1'b1; tmr_val = TMR_W'(WORD_CYC - 1);
      end
      S_DIS_WR: if (ack_ok && !abort_q) begin
        tmr_load = 1'b1; tmr_val = TMR_W'(DONE_CYC - 1);
      end
      default: ;
    endcase
  end

  prom_seq_timer #(.W(TMR_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  prom_seq_marks #(.SIZE_W(SIZE_W)) u_marks (
    .size_i (size_q),
    .idx_i  (idx_q),
    .mark_o (mark_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      size_q      <= '0;
      idx_q       <= '0;
      shadow_q    <= '0;
      abort_q     <= 1'b0;
      prom_wr_q   <= 1'b0;
      prom_addr_q <= '0;
      prom_data_q <= '0;
      mark_q      <= MK_NONE;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      prom_wr_q <= 1'b0;
      mark_q    <= MK_NONE;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          size_q  <= size_i;
          idx_q   <= '0;
          abort_q <= 1'b0;
          state_q <= S_EN_RD;
        end
        S_EN_RD: if (ctl_ack_i) begin
          if (ctl_err_i) begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            shadow_q <= ctl_rdata_i;
            state_q  <= S_EN_WR;
          end
        end
        S_EN_WR: if (ctl_ack_i) begin
          if (ctl_err_i) begin
            abort_q <= 1'b1;  // enable may have landed: try to clear it
            state_q <= S_DIS_RD;
          end else begin
            state_q <= S_SETTLE;
          end
        end
        S_SETTLE: if (tmr_zero) state_q <= (size_q == '0) ? S_DIS_RD : S_FETCH;
        S_FETCH:  state_q <= S_CAPT;
        S_CAPT: begin
          prom_wr_q   <= 1'b1;
          prom_addr_q <= PROM_BASE + ADDR_W'({idx_q, 1'b0});
          prom_data_q <= src_data_i;
          mark_q      <= mark_n;
          state_q     <= S_GAP;
        end
        S_GAP: if (tmr_zero) begin
          if (idx_q == size_q - SIZE_W'(1)) begin
            state_q <= S_DIS_RD;
          end else begin
            idx_q   <= idx_q + SIZE_W'(1);
            state_q <= S_FETCH;
          end
        end
        S_DIS_RD: if (ctl_ack_i) begin
          if (ctl_err_i) begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            shadow_q <= ctl_rdata_i;
            state_q  <= S_DIS_WR;
          end
        end
        S_DIS_WR: if (ctl_ack_i) begin
          if (ctl_err_i || abort_q) begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_TAIL;
          end
        end
        S_TAIL: if (tmr_zero) begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign src_rd_o    = (state_q == S_FETCH);
  assign src_idx_o   = idx_q;
  assign ctl_req_o   = (state_q == S_EN_RD) || (state_q == S_EN_WR) ||
                       (state_q == S_DIS_RD) || (state_q == S_DIS_WR);
  assign ctl_we_o    = (state_q == S_EN_WR) || (state_q == S_DIS_WR);
  assign ctl_wdata_o = (state_q == S_EN_WR) ? (shadow_q | WE_MASK) : (shadow_q & ~WE_MASK);
  assign prom_wr_o   = prom_wr_q;
  assign prom_addr_o = prom_addr_q;
  assign prom_data_o = prom_data_q;
  assign mark_o      = mark_q;
endmodule

// File: rtl/prom_seq_chk.sv
module prom_seq_chk #(
  parameter int unsigned CTL_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic             src_rd_o,
  input logic             ctl_req_o,
  input logic             ctl_we_o,
  input logic [CTL_W-1:0] ctl_wdata_o,
  input logic             ctl_ack_i,
  input logic             prom_wr_o,
  input logic [1:0]       mark_o
);
  a_r14_done_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  a_r2_busy_falls_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> (!busy_o && $past(busy_o)));

  a_r2_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ctl_req_o && !src_rd_o && !prom_wr_o));

  a_r3_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_req_o && !ctl_ack_i) |=> (ctl_req_o && $stable(ctl_we_o) && $stable(ctl_wdata_o)));

  a_r5_fetch_to_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_rd_o |-> ##2 prom_wr_o);

  a_r6_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prom_wr_o |=> !prom_wr_o);

  a_r9_mark_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_o != 2'd0) |-> prom_wr_o);
endmodule

bind prom_seq prom_seq_chk #(.CTL_W(CTL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .src_rd_o    (src_rd_o),
  .ctl_req_o   (ctl_req_o),
  .ctl_we_o    (ctl_we_o),
  .ctl_wdata_o (ctl_wdata_o),
  .ctl_ack_i   (ctl_ack_i),
  .prom_wr_o   (prom_wr_o),
  .mark_o      (mark_o)
);

// File: tb/prom_seq_test.sv
module prom_seq_test;
  localparam int CLK_HZ   = 4000;
  localparam int EN_CYC   = 4 * 500;
  localparam int WORD_CYC = 4 * 20;
  localparam int DONE_CYC = 4 * 500;
  localparam int SIZE_W   = 9;
  localparam int WE_BIT   = 4;
  localparam logic [31:0] WEM  = 32'h1 << WE_BIT;
  localparam logic [15:0] BASE = 16'h1000;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [SIZE_W-1:0] size_i = '0;
  logic busy_o, done_o, err_o, src_rd_o, ctl_req_o, ctl_we_o, prom_wr_o;
  logic [SIZE_W-1:0] src_idx_o;
  logic [15:0] src_data_i = '0, prom_addr_o, prom_data_o;
  logic [31:0] ctl_wdata_o, ctl_rdata_i = '0;
  logic ctl_ack_i = 1'b0, ctl_err_i = 1'b0;
  logic [1:0] mark_o;

  always #10 clk = ~clk;

  prom_seq #(.CLK_HZ(CLK_HZ), .SIZE_W(SIZE_W), .WE_BIT(WE_BIT), .PROM_BASE(BASE)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .size_i(size_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .src_rd_o(src_rd_o), .src_idx_o(src_idx_o), .src_data_i(src_data_i),
    .ctl_req_o(ctl_req_o), .ctl_we_o(ctl_we_o), .ctl_wdata_o(ctl_wdata_o),
    .ctl_rdata_i(ctl_rdata_i), .ctl_ack_i(ctl_ack_i), .ctl_err_i(ctl_err_i),
    .prom_wr_o(prom_wr_o), .prom_addr_o(prom_addr_o), .prom_data_o(prom_data_o),
    .mark_o(mark_o)
  );

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  logic [15:0] image [512];
  logic [31:0] ctl_model;
  int err_at = -1;
  // control access log
  int n_acc;
  int acc_cyc [8], req_cyc [8];
  logic acc_we [8];
  logic [31:0] acc_wdata [8];
  // strobe log
  int n_st, n_src, n_done, n_err, end_cyc;
  int st_cyc [512];
  logic [15:0] st_addr [512], st_data [512];
  logic [1:0] st_mark [512];
  bit fin, end_busy;

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int exp_mark(input int i, input int sz);
    if (i == sz / 4) return 1;
    if (i == sz / 2) return 2;
    if (i == (3 * sz) / 4) return 3;
    return 0;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    #(20 * WD_LIMIT);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_LIMIT);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // control register responder, random latency 0..2
  initial begin
    bit pend = 0;
    int wt = 0;
    forever begin
      @(negedge clk);
      ctl_ack_i = 1'b0;
      ctl_err_i = 1'b0;
      if (ctl_req_o) begin
        if (!pend) begin
          pend = 1;
          req_cyc[n_acc] = cyc;
          wt = $urandom % 3;
        end
        if (wt == 0) begin
          ctl_ack_i = 1'b1;
          ctl_err_i = (n_acc == err_at);
          ctl_rdata_i = ctl_model;
          if (ctl_we_o && !ctl_err_i) ctl_model = ctl_wdata_o;
          acc_we[n_acc] = ctl_we_o;
          acc_wdata[n_acc] = ctl_wdata_o;
          acc_cyc[n_acc] = cyc;
          n_acc++;
          pend = 0;
        end else wt--;
      end
    end
  end

  // source buffer: data valid the cycle after the request, junk otherwise
  initial begin
    bit prev_rd = 0;
    int prev_idx = 0;
    forever begin
      @(negedge clk);
      src_data_i = prev_rd ? image[prev_idx] : 16'($urandom);
      prev_rd = src_rd_o;
      prev_idx = int'(src_idx_o);
    end
  end

  always @(negedge clk) begin
    if (src_rd_o) n_src++;
    if (prom_wr_o && n_st < 512) begin
      st_cyc[n_st] = cyc; st_addr[n_st] = prom_addr_o;
      st_data[n_st] = prom_data_o; st_mark[n_st] = mark_o;
      n_st++;
    end else if (mark_o != 0) begin
      check(0, "R9 marker without strobe", mark_o, 0);
    end
    if (done_o) n_done++;
    if (err_o) n_err++;
    if ((done_o || err_o) && !fin) begin
      fin = 1; end_cyc = cyc; end_busy = busy_o;
    end
  end

  task automatic run_job(input int sz, input int eat, input bit poke);
    logic [31:0] init;
    int last;
    init = $urandom & ~WEM;
    ctl_model = init;
    for (int i = 0; i < sz; i++) image[i] = 16'($urandom);
    n_acc = 0; n_st = 0; n_src = 0; n_done = 0; n_err = 0; fin = 0;
    err_at = eat;
    @(negedge clk);
    check(busy_o == 0, "R2 idle before start", busy_o, 0);
    start_i = 1'b1; size_i = SIZE_W'(sz);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1, "R2 busy after start", busy_o, 1);
    if (poke) begin
      repeat (50) @(negedge clk);
      start_i = 1'b1; size_i = SIZE_W'(sz + 7);
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!fin) @(negedge clk);
    repeat (6) @(negedge clk);
    check(end_busy == 0, "R2 busy low at end", end_busy, 0);
    check(n_done + n_err == 1, "R14 one end pulse", n_done + n_err, 1);
    if (eat < 0) begin
      check(n_done == 1 && n_err == 0, "R14 done not err", n_err, 0);
      check(n_acc == 4, "R3 access count", n_acc, 4);
      check(!acc_we[0] && acc_we[1] && !acc_we[2] && acc_we[3], "R3 access kinds",
            {acc_we[0], acc_we[1], acc_we[2], acc_we[3]}, 4'b0101);
      check(acc_wdata[1] == (init | WEM), "R3 enable rmw", acc_wdata[1], init | WEM);
      check(acc_wdata[3] == init, "R7 disable rmw", acc_wdata[3], init);
      check(n_st == sz, "R5 word count", n_st, sz);
      check(n_src == sz, "R10 source reads", n_src, sz);
      for (int i = 0; i < n_st && i < sz; i++) begin
        check(st_addr[i] == BASE + 16'(2 * i), "R5 address", st_addr[i], BASE + 16'(2 * i));
        check(st_data[i] == image[i], "R5 data", st_data[i], image[i]);
        check(int'(st_mark[i]) == exp_mark(i, sz), "R9 marker", st_mark[i], exp_mark(i, sz));
        if (i > 0)
          check(st_cyc[i] - st_cyc[i-1] == WORD_CYC + 2, "R6 spacing",
                st_cyc[i] - st_cyc[i-1], WORD_CYC + 2);
      end
      if (sz > 0 && n_st > 0) begin
        last = n_st - 1;
        check(st_cyc[0] == acc_cyc[1] + EN_CYC + 3, "R4 first strobe",
              st_cyc[0] - acc_cyc[1], EN_CYC + 3);
        check(req_cyc[2] == st_cyc[last] + WORD_CYC, "R7 disable request",
              req_cyc[2] - st_cyc[last], WORD_CYC);
      end else begin
        check(req_cyc[2] == acc_cyc[1] + EN_CYC + 1, "R10 disable request",
              req_cyc[2] - acc_cyc[1], EN_CYC + 1);
      end
      check(end_cyc == acc_cyc[3] + DONE_CYC + 1, "R8 done timing",
            end_cyc - acc_cyc[3], DONE_CYC + 1);
      check(ctl_model == init, "R7 final control", ctl_model, init);
    end else begin
      check(n_err == 1 && n_done == 0, "R14 err not done", n_done, 0);
      case (eat)
        0: begin
          check(n_acc == 1, "R11 no write after failed read", n_acc, 1);
          check(end_cyc == acc_cyc[0] + 1, "R11 err timing", end_cyc - acc_cyc[0], 1);
          check(n_st == 0 && n_src == 0, "R11 no strobes", n_st, 0);
          check(ctl_model == init, "R11 control untouched", ctl_model, init);
        end
        1: begin
          check(n_acc == 4 && !acc_we[2] && acc_we[3], "R12 abort rmw", n_acc, 4);
          check(acc_wdata[3] == init, "R12 abort clears enable", acc_wdata[3], init);
          check(end_cyc == acc_cyc[3] + 1, "R12 err timing", end_cyc - acc_cyc[3], 1);
          check(n_st == 0 && n_src == 0, "R12 no strobes", n_st, 0);
        end
        default: begin
          check(n_acc == eat + 1, "R13 no further access", n_acc, eat + 1);
          check(end_cyc == acc_cyc[eat] + 1, "R13 err timing", end_cyc - acc_cyc[eat], 1);
          check(n_st == sz, "R13 words written", n_st, sz);
          check(ctl_model == (init | WEM), "R13 enable left set", ctl_model, init | WEM);
        end
      endcase
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !err_o && !src_rd_o && !ctl_req_o && !prom_wr_o && mark_o == 0,
          "R1 reset outputs", {busy_o, done_o, err_o, src_rd_o, ctl_req_o, prom_wr_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy_o && !ctl_req_o && !prom_wr_o, "R1 idle after reset", busy_o, 0);
    run_job(16, -1, 1);
    run_job(1, -1, 0);
    run_job(2, -1, 0);
    run_job(3, -1, 0);
    run_job(0, -1, 0);
    for (int k = 0; k < 3; k++) run_job(4 + int'($urandom % 37), -1, 0);
    run_job(6, 0, 0);
    run_job(6, 1, 0);
    run_job(6, 2, 0);
    run_job(6, 3, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule